// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out interrupt entry for a small 8-bit processor core. Requesters raise one of three request kinds: maskable, non-maskable or restart. A single slot holds the request until the core signals an instruction boundary. At that boundary the sequencer decides whether the request is taken. It checks the live interrupt-disable flag for maskable requests and an external enable bit for non-maskable ones.

A taken maskable or non-maskable request saves the return address and a packed copy of the core's flags onto a downward-growing stack. The stack is confined to address page one. The block then reads a two-byte vector over a byte-wide synchronous memory port and hands the core a new program counter. A restart request skips the stack and only fetches its vector. The core holds off instruction execution while `busy` is high. It loads `pc_new` and `i_new` on the single-cycle `pc_load` pulse.

Top module: `intr_entry_seq`

## Requirements
- R1: After a synchronous reset, `sp_out` is 0x01FF, `i_new` is 1, `busy` and `pc_load` are 0, and no memory access is issued.
- R2: Request codes on `req_kind` are 0 = maskable, 1 = non-maskable, 2 = restart. Code 3 is ignored and leaves nothing pending.
- R3: One request can be pending. A maskable request that arrives while another request is pending is ignored. A non-maskable or restart request replaces whatever is pending.
- R4: When the boundary finds a maskable request pending and `cur_i` is 1, the request is dropped. There is no memory access, `busy` stays low, and the slot is emptied.
- R5: When the boundary finds a non-maskable request pending and `nmi_en` is 0, the request is dropped and the slot is emptied.
- R6: A taken maskable or non-maskable entry issues three writes. PC[15:8] goes to the current stack address, PC[7:0] to the next lower one, and then the status byte. The stack pointer drops by one after each write.
- R7: The pushed status byte is {N, V, 1, 0, D, I, Z, C}, with C in bit 0 and N in bit 7. Bit 4 is 0 and bit 5 is 1.
- R8: Vectors are read low byte first and then high byte. The addresses are 0xFFFE/0xFFFF for maskable, 0xFFFA/0xFFFB for non-maskable and 0xFFFC/0xFFFD for restart. `pc_new` is high byte × 256 + low byte. Restart makes no write and leaves the stack pointer unchanged.
- R9: Every stack write address has high byte 0x01. The pointer wraps from 0x0100 to 0x01FF.
- R10: `i_new` becomes 1 after a maskable or restart entry. After a non-maskable entry it equals the `cur_i` seen at acceptance.
- R11: `busy` rises in the cycle after the accepting boundary. It lasts 6 cycles for entries that push and 3 cycles for restart. `pc_load` is a one-cycle pulse in the first cycle after `busy` falls.
- R12: A boundary with nothing pending does nothing. A request that arrives while `busy` is high is held and served at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Request code (0 maskable, 1 non-maskable, 2 restart) |
| boundary | input | 1 | Core is at an instruction boundary |
| nmi_en | input | 1 | Non-maskable request enable |
| pc_in | input | 16 | Return address to save |
| cur_c | input | 1 | Carry flag |
| cur_z | input | 1 | Zero flag |
| cur_i | input | 1 | Interrupt-disable flag |
| cur_d | input | 1 | Decimal flag |
| cur_v | input | 1 | Overflow flag |
| cur_n | input | 1 | Negative flag |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the read |
| busy | output | 1 | Entry in progress |
| pc_load | output | 1 | New PC and I flag valid this cycle |
| pc_new | output | 16 | Program counter from the vector |
| i_new | output | 1 | Interrupt-disable flag after entry |
| sp_out | output | 16 | Current stack address (page one) |

## Verification
On every cycle, the assertions check the following. Stack writes stay inside page one, and each write moves the pointer down by one. A pending non-maskable or restart request is never displaced by a maskable one, and a restart entry never writes. The end of `busy` always coincides with a single `pc_load` pulse, and a masked request never starts an entry. The scenarios alone show the remaining behaviour. These are the exact byte order and packing on the stack, the vector values, the replacement rules between request kinds, the wrap at the bottom of page one, and the flag handed back for each kind.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam logic [1:0] KIND_MASK = 2'd0;
  localparam logic [1:0] KIND_NMI  = 2'd1;
  localparam logic [1:0] KIND_RST  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_FINISH
  } seq_state_e;

  // Flag byte layout: N V 1 0 D I Z C (bit 7 down to bit 0)
  function automatic logic [7:0] pack_status(input logic c, input logic z,
                                             input logic i, input logic d,
                                             input logic v, input logic n);
    return {n, v, 1'b1, 1'b0, d, i, z, c};
  endfunction

endpackage

// File: rtl/intr_pend_slot.sv
module intr_pend_slot
  import intr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       take,
  output logic       pend_valid,
  output logic [1:0] pend_kind
);

  logic slot_free;
  logic load_new;

  // The slot counts as free in the cycle it is handed to the sequencer
  assign slot_free = !pend_valid || take;

  always_comb begin
    case (req_kind)
      KIND_NMI, KIND_RST: load_new = req_valid;
      KIND_MASK:          load_new = req_valid && slot_free;
      default:            load_new = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_kind  <= KIND_MASK;
    end else if (load_new) begin
      pend_valid <= 1'b1;
      pend_kind  <= req_kind;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R3: a maskable request never displaces a pending one
  a_r3_keep_pending: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !take && req_valid && req_kind == KIND_MASK)
      |=> (pend_valid && $stable(pend_kind)));

  // R2: code 3 never becomes pending
  a_r2_no_code3: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> (pend_kind != 2'd3));

endmodule

// File: rtl/intr_stack_ptr.sv
module intr_stack_ptr #(
  parameter int AW = 16,
  parameter int SPW = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  output logic [AW-1:0] sp_addr
);

  localparam int PW = AW - SPW;
  localparam logic [PW-1:0] PAGE = PW'(STACK_PAGE);

  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst) sp_q <= '1;
    else if (push) sp_q <= sp_q - SPW'(1);
  end

  // High part is fixed, so the low part wraps within the page
  assign sp_addr = {PAGE, sp_q};

  // R6: each push moves the pointer down by exactly one
  a_r6_push_dec: assert property (@(posedge clk) disable iff (rst)
    push |=> (sp_addr[SPW-1:0] == $past(sp_addr[SPW-1:0]) - SPW'(1)));

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SPW = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          boundary,
  input  logic          nmi_en,
  input  logic [AW-1:0] pc_in,
  input  logic          cur_c,
  input  logic          cur_z,
  input  logic          cur_i,
  input  logic          cur_d,
  input  logic          cur_v,
  input  logic          cur_n,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          pc_load,
  output logic [AW-1:0] pc_new,
  output logic          i_new,
  output logic [AW-1:0] sp_out
);

  localparam int PW = AW - SPW;
  localparam logic [PW-1:0] PAGE = PW'(STACK_PAGE);
  localparam logic [AW-1:0] ADDR_TOP = '1;
  localparam logic [AW-1:0] VEC_MASK = ADDR_TOP - AW'(1);
  localparam logic [AW-1:0] VEC_NMI  = ADDR_TOP - AW'(5);
  localparam logic [AW-1:0] VEC_RST  = ADDR_TOP - AW'(3);

  seq_state_e    st;
  logic [1:0]    act_kind;
  logic [AW-1:0] pc_cap;
  logic [7:0]    stat_cap;
  logic          i_cap;
  logic [DW-1:0] vec_lo_q;
  logic [AW-1:0] pc_new_q;
  logic          pc_load_q;
  logic          i_new_q;

  logic          pend_valid;
  logic [1:0]    pend_kind;
  logic          take;
  logic          go;
  logic          push;
  logic [AW-1:0] sp_addr;
  logic [AW-1:0] vec_base;

  intr_pend_slot u_slot (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_kind  (pend_kind)
  );

  intr_stack_ptr #(
    .AW         (AW),
    .SPW        (SPW),
    .STACK_PAGE (STACK_PAGE)
  ) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .sp_addr (sp_addr)
  );

  // Acceptance decision at the boundary
  always_comb begin
    take = (st == ST_IDLE) && boundary && pend_valid;
    case (pend_kind)
      KIND_MASK: go = !cur_i;
      KIND_NMI:  go = nmi_en;
      KIND_RST:  go = 1'b1;
      default:   go = 1'b0;
    endcase
  end

  always_comb begin
    case (act_kind)
      KIND_NMI: vec_base = VEC_NMI;
      KIND_RST: vec_base = VEC_RST;
      default:  vec_base = VEC_MASK;
    endcase
  end

  assign push = (st == ST_PUSH_HI) || (st == ST_PUSH_LO) || (st == ST_PUSH_ST);

  // Memory command decoded from the registered state
  always_comb begin
    mem_en    = push || (st == ST_VEC_LO) || (st == ST_VEC_HI);
    mem_we    = push;
    mem_addr  = push ? sp_addr :
                ((st == ST_VEC_HI) ? vec_base + AW'(1) : vec_base);
    case (st)
      ST_PUSH_HI: mem_wdata = pc_cap[AW-1 -: DW];
      ST_PUSH_LO: mem_wdata = pc_cap[DW-1:0];
      ST_PUSH_ST: mem_wdata = stat_cap;
      default:    mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      act_kind  <= KIND_MASK;
      pc_cap    <= '0;
      stat_cap  <= '0;
      i_cap     <= 1'b1;
      vec_lo_q  <= '0;
      pc_new_q  <= '0;
      pc_load_q <= 1'b0;
      i_new_q   <= 1'b1;
    end else begin
      pc_load_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take && go) begin
            act_kind <= pend_kind;
            pc_cap   <= pc_in;
            stat_cap <= pack_status(cur_c, cur_z, cur_i, cur_d, cur_v, cur_n);
            i_cap    <= cur_i;
            st       <= (pend_kind == KIND_RST) ? ST_VEC_LO : ST_PUSH_HI;
          end
        end
        ST_PUSH_HI: st <= ST_PUSH_LO;
        ST_PUSH_LO: st <= ST_PUSH_ST;
        ST_PUSH_ST: st <= ST_VEC_LO;
        ST_VEC_LO:  st <= ST_VEC_HI;
        ST_VEC_HI: begin
          vec_lo_q <= mem_rdata;
          st       <= ST_FINISH;
        end
        ST_FINISH: begin
          pc_new_q  <= {mem_rdata, vec_lo_q};
          pc_load_q <= 1'b1;
          i_new_q   <= (act_kind == KIND_NMI) ? i_cap : 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign pc_load = pc_load_q;
  assign pc_new  = pc_new_q;
  assign i_new   = i_new_q;
  assign sp_out  = sp_addr;

  // R9: stack writes stay inside page one
  a_r9_stack_page: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:SPW] == PAGE));

  // R11: the end of an entry always delivers the new PC
  a_r11_load_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> pc_load);

  // R11: the load strobe lasts one cycle
  a_r11_load_pulse: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);

  // R8: a restart entry never writes the stack
  a_r8_restart_no_push: assert property (@(posedge clk) disable iff (rst)
    (busy && act_kind == KIND_RST) |-> !mem_we);

  // R4: a masked request never starts an entry
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (take && pend_kind == KIND_MASK && cur_i) |=> !busy);

endmodule

// File: tb/intr_entry_seq_test.sv
module intr_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        boundary = 1'b0;
  logic        nmi_en = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic        cur_c = 1'b0, cur_z = 1'b0, cur_i = 1'b0;
  logic        cur_d = 1'b0, cur_v = 1'b0, cur_n = 1'b0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h0;
  logic        busy, pc_load, i_new;
  logic [15:0] pc_new, sp_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int bad_page = 0;
  bit saw_wrap = 1'b0;
  logic [15:0] last_wr = 16'h0;
  logic [7:0] stk [256];
  logic [7:0] exp_sp = 8'hFF;

  always #5 clk = ~clk;

  intr_entry_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .boundary(boundary), .nmi_en(nmi_en), .pc_in(pc_in),
    .cur_c(cur_c), .cur_z(cur_z), .cur_i(cur_i), .cur_d(cur_d),
    .cur_v(cur_v), .cur_n(cur_n),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .pc_load(pc_load), .pc_new(pc_new), .i_new(i_new),
    .sp_out(sp_out)
  );

  // Memory model: stack page writes, vector reads with one-cycle latency
  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      stk[mem_addr[7:0]] <= mem_wdata;
      if (mem_addr[15:8] != 8'h01) bad_page <= bad_page + 1;
      if (mem_addr == 16'h01FF && last_wr == 16'h0100) saw_wrap <= 1'b1;
      last_wr <= mem_addr;
    end else if (mem_en) begin
      case (mem_addr)
        16'hFFFE: mem_rdata <= 8'h5A;
        16'hFFFF: mem_rdata <= 8'hE0;
        16'hFFFA: mem_rdata <= 8'h11;
        16'hFFFB: mem_rdata <= 8'hA1;
        16'hFFFC: mem_rdata <= 8'h3C;
        16'hFFFD: mem_rdata <= 8'hC0;
        default:  mem_rdata <= 8'h00;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // f = {n, v, d, i, z, c}
  task automatic pulse_boundary(input logic [15:0] pc, input logic [5:0] f);
    @(negedge clk);
    pc_in = pc;
    {cur_n, cur_v, cur_d, cur_i, cur_z, cur_c} = f;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic observe(output int nb, output bit saw, output logic [15:0] pcv,
                         output logic iv);
    nb = 0; saw = 1'b0; pcv = 16'h0; iv = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (busy) nb++;
      if (pc_load && !saw) begin
        saw = 1'b1; pcv = pc_new; iv = i_new;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_none(input string req);
    int nb; bit saw; logic [15:0] pcv; logic iv;
    observe(nb, saw, pcv, iv);
    chk(nb == 0 && !saw, req, {nb[15:0], 15'h0, saw}, 32'h0);
    chk(sp_out == {8'h01, exp_sp}, req, sp_out, {8'h01, exp_sp});
  endtask

  // Full entry with pushes; checks stack bytes, vector, flag, latency
  task automatic expect_push_entry(input logic [15:0] pc, input logic [5:0] f,
                                   input logic [15:0] vec, input logic exp_i,
                                   input string req);
    int nb; bit saw; logic [15:0] pcv; logic iv;
    logic [7:0] st_exp;
    observe(nb, saw, pcv, iv);
    st_exp = {f[5], f[4], 1'b1, 1'b0, f[3], f[2], f[1], f[0]};
    chk(nb == 6, {req, " R11 busy length"}, nb, 6);
    chk(saw && pcv == vec, {req, " R8 vector"}, pcv, vec);
    chk(iv == exp_i, {req, " R10 i_new"}, iv, exp_i);
    chk(stk[exp_sp] == pc[15:8], {req, " R6 pc high"}, stk[exp_sp], pc[15:8]);
    chk(stk[8'(exp_sp - 8'd1)] == pc[7:0], {req, " R6 pc low"},
        stk[8'(exp_sp - 8'd1)], pc[7:0]);
    chk(stk[8'(exp_sp - 8'd2)] == st_exp, {req, " R7 status"},
        stk[8'(exp_sp - 8'd2)], st_exp);
    exp_sp = exp_sp - 8'd3;
    chk(sp_out == {8'h01, exp_sp}, {req, " R9 pointer"}, sp_out, {8'h01, exp_sp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nb; bit saw; logic [15:0] pcv; logic iv;
    logic [15:0] pc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(sp_out == 16'h01FF, "R1 sp", sp_out, 16'h01FF);
    chk(i_new == 1'b1, "R1 i_new", i_new, 1);
    chk(!busy && !pc_load && !mem_en, "R1 idle",
        {busy, pc_load, mem_en}, 0);

    // R12 boundary with nothing pending
    pulse_boundary(16'h1234, 6'h00);
    expect_none("R12 empty boundary");

    // R2 code 3 ignored
    send_req(2'd3);
    pulse_boundary(16'h1234, 6'h00);
    expect_none("R2 code 3");

    // Maskable sweep over all flag combinations
    for (int f = 0; f < 64; f++) begin
      pc = 16'h1000 + 16'(f) * 16'h0123;
      send_req(2'd0);
      pulse_boundary(pc, 6'(f));
      if (f[2]) begin
        expect_none("R4 masked");
        pulse_boundary(pc, 6'h00);
        expect_none("R4 slot emptied");
      end else begin
        expect_push_entry(pc, 6'(f), 16'hE05A, 1'b1, "R6 maskable");
      end
    end

    // R5 non-maskable disabled
    nmi_en = 1'b0;
    send_req(2'd1);
    pulse_boundary(16'h2222, 6'h00);
    expect_none("R5 nmi dropped");
    pulse_boundary(16'h2222, 6'h00);
    expect_none("R5 slot emptied");

    // R10 non-maskable keeps current I
    nmi_en = 1'b1;
    send_req(2'd1);
    pulse_boundary(16'h3456, 6'b000100);
    expect_push_entry(16'h3456, 6'b000100, 16'hA111, 1'b1, "R10 nmi i=1");
    send_req(2'd1);
    pulse_boundary(16'h3457, 6'b100001);
    expect_push_entry(16'h3457, 6'b100001, 16'hA111, 1'b0, "R10 nmi i=0");

    // R3 replacement rules
    send_req(2'd0);
    send_req(2'd1);
    pulse_boundary(16'h4001, 6'b000100);
    expect_push_entry(16'h4001, 6'b000100, 16'hA111, 1'b1, "R3 nmi replaces");
    send_req(2'd1);
    send_req(2'd0);
    pulse_boundary(16'h4002, 6'b000000);
    expect_push_entry(16'h4002, 6'b000000, 16'hA111, 1'b0, "R3 maskable ignored");

    // R8 restart replaces maskable, no pushes
    send_req(2'd0);
    send_req(2'd2);
    pulse_boundary(16'h5000, 6'b000000);
    observe(nb, saw, pcv, iv);
    chk(nb == 3, "R11 restart busy", nb, 3);
    chk(saw && pcv == 16'hC03C, "R8 restart vector", pcv, 16'hC03C);
    chk(iv == 1'b1, "R10 restart i_new", iv, 1);
    chk(sp_out == {8'h01, exp_sp}, "R8 restart no push", sp_out, {8'h01, exp_sp});

    // R12 request during an entry is held for the next boundary
    send_req(2'd0);
    pulse_boundary(16'h6000, 6'b000000);
    send_req(2'd1);
    observe(nb, saw, pcv, iv);
    chk(saw && pcv == 16'hE05A, "R12 first entry", pcv, 16'hE05A);
    chk(stk[exp_sp] == 8'h60, "R12 first entry stack", stk[exp_sp], 8'h60);
    exp_sp = exp_sp - 8'd3;
    pulse_boundary(16'h6100, 6'b000000);
    expect_push_entry(16'h6100, 6'b000000, 16'hA111, 1'b0, "R12 held nmi");

    // R9 run the pointer across the bottom of the page
    for (int e = 0; e < 50; e++) begin
      pc = 16'h7000 + 16'(e) * 16'h0101;
      send_req(2'd0);
      pulse_boundary(pc, 6'(e & 59));
      expect_push_entry(pc, 6'(e & 59), 16'hE05A, 1'b1, "R9 wrap run");
    end
    chk(saw_wrap, "R9 wrap 0x0100 to 0x01FF", saw_wrap, 1);
    chk(bad_page == 0, "R9 page one", bad_page, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule